// File: doc/BRIEF.md
# DDR SDRAM Bank Timing Guard

The guard sits between a memory controller's scheduler and the command port of a four-bank DDR SDRAM. Each clock the scheduler offers one candidate command: activate, read, write, precharge, or auto-refresh. Each command carries a bank number and the row-address bit 10 flag. The guard keeps the open or closed state of every bank and a set of per-bank and shared spacing counters. It raises `cmd_ready` only when sending the command in this cycle would meet every minimum spacing rule. A command is taken as issued in any cycle where `cmd_ready` is high. The guard then updates its state on that clock edge.

All analog timing limits are parameters in picoseconds. At elaboration each one becomes a clock count as ceil(t / tCK). Burst length and CAS latency are also parameters. CAS latency is given in half cycles, so 2.5 is written as 5. Some commands are wrong for the current bank state: a column access to a closed bank, an activate to an open bank, a refresh while any bank is open, or an unused opcode. The guard flags these on `cmd_illegal` and never makes them ready. Each bank also reports when it has stayed open longer than the maximum active time.

Top module: `ddr_bank_guard`

## Requirements
- R1: After reset all four banks are closed, `cmd_ready` and `cmd_illegal` are low, and no bank is flagged overdue.
- R2: A read or write to a bank is not ready until tRCD clock counts after that bank's activate (3 cycles at defaults).
- R3: A precharge that closes an open bank is not ready until tRAS counts after its activate (6 cycles at defaults).
- R4: `bank_overdue[b]` rises in the cycle that is exactly ceil(tRASmax/tCK) cycles after bank b's activate, and stays high while the bank remains open. It drops once the bank is closed.
- R5: An activate waits tRC after the previous activate to the same bank (9 cycles) and tRRD after an activate to any bank (2 cycles).
- R6: After a precharge closes a bank, an activate to that bank waits tRP (3 cycles).
- R7: A precharge (op 3) with the bit-10 flag low closes only the addressed bank. With the flag high it closes every bank, whatever the bank address.
- R8: A read (op 1) with the flag high closes the bank at issue. The bank can be activated again after max(remaining tRAS, BL/2) + tRP cycles.
- R9: A write (op 2) with the flag high closes the bank at issue. The bank can be activated again after max(remaining tRAS + tRP, 1 + BL/2 + tDAL) cycles, where tDAL = ceil(tWR/tCK) + ceil(tRP/tCK).
- R10: Column spacing is enforced as follows. Any column command waits BL/2 after the previous one. A write waits ceil(CL) + BL/2 after a read (5 cycles at defaults). A read waits 1 + BL/2 + tWTR after a write (4 cycles). A precharge waits BL/2 after a read and 1 + BL/2 + tWR after a write to the bank.
- R11: An auto-refresh (op 4) is illegal while any bank is open. It waits for tRP and tRC on every bank. After it, no command is ready for tRFC (10 cycles).
- R12: Opcodes are activate = 0, read = 1, write = 2, precharge = 3, refresh = 4. Values 5 to 7 are illegal. `cmd_ready` is never high together with `cmd_illegal`, and never high without `cmd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A candidate command is offered this cycle |
| cmd_op | input | 3 | Command opcode |
| cmd_bank | input | 2 | Target bank |
| cmd_ap | input | 1 | Row-address bit 10: auto-precharge or precharge-all |
| cmd_ready | output | 1 | Command is legal and meets all spacing; it issues this cycle |
| cmd_illegal | output | 1 | Command is wrong for the current bank state or opcode |
| bank_open | output | 4 | Open flag per bank |
| bank_overdue | output | 4 | Bank has been open longer than the maximum active time |

## Verification
The bench keeps the default 7.5 ns clock, burst length 4 and CAS latency 2.5. Under these values tRC works out to 9 cycles, tRP to 3 and tDAL to 5, so the auto-precharge recovery paths produce readiness cycles that differ from plain write recovery. The maximum active time is shortened to 300 ns (40 cycles), which lets the overdue flag be reached and cleared in a short run. Each spacing rule is probed one cycle before and in the cycle it opens.

// File: rtl/bkg_pkg.sv
package bkg_pkg;

    typedef enum logic [2:0] {
        OP_ACT  = 3'd0,
        OP_RD   = 3'd1,
        OP_WR   = 3'd2,
        OP_PRE  = 3'd3,
        OP_RFSH = 3'd4
    } op_e;

    typedef struct packed {
        logic act;
        logic rd;
        logic wr;
        logic pre;
        logic rfsh;
        logic bad;
    } op_dec_t;

    function automatic int ns_to_ck(input int t_ps, input int tck_ps);
        return (t_ps + tck_ps - 1) / tck_ps;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic op_dec_t decode_op(input logic [2:0] op);
        op_dec_t d;
        d      = '0;
        d.act  = (op == OP_ACT);
        d.rd   = (op == OP_RD);
        d.wr   = (op == OP_WR);
        d.pre  = (op == OP_PRE);
        d.rfsh = (op == OP_RFSH);
        d.bad  = (op > OP_RFSH);
        return d;
    endfunction

endpackage

// File: rtl/bkg_bank.sv
module bkg_bank #(
    parameter int CW         = 6,
    parameter int AGE_W      = 6,
    parameter int RCD_CK     = 3,
    parameter int RAS_CK     = 6,
    parameter int RC_CK      = 9,
    parameter int RP_CK      = 3,
    parameter int R2P_CK     = 2,
    parameter int W2P_CK     = 5,
    parameter int WEND_CK    = 3,
    parameter int DAL_CK     = 5,
    parameter int RAS_MAX_CK = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic act_i,
    input  logic pre_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic ap_i,
    output logic open_o,
    output logic rcd_ok_o,
    output logic pre_ok_o,
    output logic act_ok_o,
    output logic over_o
);

    localparam logic [CW-1:0]    RCD_L  = CW'(RCD_CK - 1);
    localparam logic [CW-1:0]    RAS_L  = CW'(RAS_CK - 1);
    localparam logic [CW-1:0]    RC_L   = CW'(RC_CK - 1);
    localparam logic [CW-1:0]    RP_L   = CW'(RP_CK - 1);
    localparam logic [CW-1:0]    R2P_L  = CW'(R2P_CK - 1);
    localparam logic [CW-1:0]    W2P_L  = CW'(W2P_CK - 1);
    localparam logic [CW-1:0]    R2P_V  = CW'(R2P_CK);
    localparam logic [CW-1:0]    RP_V   = CW'(RP_CK);
    localparam logic [CW-1:0]    WDAL_V = CW'(WEND_CK + DAL_CK);
    localparam logic [AGE_W-1:0] AGE_LIM = AGE_W'(RAS_MAX_CK);

    logic [CW-1:0]    rcd_q, ras_q, rc_q, rp_q, wr_q;
    logic [AGE_W-1:0] age_q;
    logic             open_q;
    logic [CW-1:0]    rd_base, wr_sum, ap_rd, ap_wr, wr_next;

    function automatic logic [CW-1:0] dn(input logic [CW-1:0] v);
        return (v == '0) ? v : v - CW'(1);
    endfunction

    always_comb begin
        rd_base = (ras_q > R2P_V) ? ras_q : R2P_V;
        ap_rd   = rd_base + RP_L;
        wr_sum  = ras_q + RP_V;
        ap_wr   = ((wr_sum > WDAL_V) ? wr_sum : WDAL_V) - CW'(1);
        wr_next = dn(wr_q);
        if (rd_i && (R2P_L > wr_next)) wr_next = R2P_L;
        if (wr_i && (W2P_L > wr_next)) wr_next = W2P_L;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rcd_q  <= '0;
            ras_q  <= '0;
            rc_q   <= '0;
            rp_q   <= '0;
            wr_q   <= '0;
            age_q  <= '0;
            open_q <= 1'b0;
        end else begin
            rcd_q <= act_i ? RCD_L : dn(rcd_q);
            ras_q <= act_i ? RAS_L : dn(ras_q);
            rc_q  <= act_i ? RC_L  : dn(rc_q);
            wr_q  <= wr_next;
            if (act_i)
                age_q <= AGE_W'(1);
            else if (open_q && age_q < AGE_LIM)
                age_q <= age_q + AGE_W'(1);
            if (pre_i)
                rp_q <= RP_L;
            else if (rd_i && ap_i)
                rp_q <= ap_rd;
            else if (wr_i && ap_i)
                rp_q <= ap_wr;
            else
                rp_q <= dn(rp_q);
            if (act_i)
                open_q <= 1'b1;
            else if (pre_i || ((rd_i || wr_i) && ap_i))
                open_q <= 1'b0;
        end
    end

    assign open_o   = open_q;
    assign rcd_ok_o = (rcd_q == '0);
    assign pre_ok_o = (ras_q == '0) && (wr_q == '0);
    assign act_ok_o = (rp_q == '0) && (rc_q == '0);
    assign over_o   = open_q && (age_q >= AGE_LIM);

    // R2
    rcd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (act_i && RCD_CK > 1) |=> !rcd_ok_o);

    // R3
    ras_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (act_i && RAS_CK > 1) |=> !pre_ok_o);

    // R6
    pre_close_chk: assert property (@(posedge clk) disable iff (rst)
        (pre_i && RP_CK > 1) |=> (!open_o && !act_ok_o));

    // R4
    over_open_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(over_o) |-> $past(open_o));

endmodule

// File: rtl/bkg_bus.sv
module bkg_bus #(
    parameter int CW     = 6,
    parameter int COL_CK = 2,
    parameter int R2W_CK = 5,
    parameter int W2R_CK = 4,
    parameter int RRD_CK = 2,
    parameter int RFC_CK = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic act_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic rfsh_i,
    output logic rd_ok_o,
    output logic wr_ok_o,
    output logic rrd_ok_o,
    output logic rfc_ok_o
);

    logic [CW-1:0] col_q, r2w_q, w2r_q, rrd_q, rfc_q;

    function automatic logic [CW-1:0] dn(input logic [CW-1:0] v);
        return (v == '0) ? v : v - CW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q <= '0;
            r2w_q <= '0;
            w2r_q <= '0;
            rrd_q <= '0;
            rfc_q <= '0;
        end else begin
            col_q <= (rd_i || wr_i) ? CW'(COL_CK - 1) : dn(col_q);
            r2w_q <= rd_i   ? CW'(R2W_CK - 1) : dn(r2w_q);
            w2r_q <= wr_i   ? CW'(W2R_CK - 1) : dn(w2r_q);
            rrd_q <= act_i  ? CW'(RRD_CK - 1) : dn(rrd_q);
            rfc_q <= rfsh_i ? CW'(RFC_CK - 1) : dn(rfc_q);
        end
    end

    assign rd_ok_o  = (col_q == '0) && (w2r_q == '0);
    assign wr_ok_o  = (col_q == '0) && (r2w_q == '0);
    assign rrd_ok_o = (rrd_q == '0);
    assign rfc_ok_o = (rfc_q == '0);

    // R11
    rfc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rfsh_i && RFC_CK > 1) |=> !rfc_ok_o);

    // R10
    r2w_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_i && R2W_CK > 1) |=> !wr_ok_o);

    // R5
    rrd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (act_i && RRD_CK > 1) |=> !rrd_ok_o);

endmodule

// File: rtl/ddr_bank_guard.sv
module ddr_bank_guard
    import bkg_pkg::*;
#(
    parameter int NUM_BANKS    = 4,
    parameter int TCK_PS       = 7500,
    parameter int T_RCD_PS     = 20000,
    parameter int T_RAS_PS     = 45000,
    parameter int T_RAS_MAX_PS = 120000000,
    parameter int T_RC_PS      = 65000,
    parameter int T_RRD_PS     = 15000,
    parameter int T_RP_PS      = 20000,
    parameter int T_WR_PS      = 15000,
    parameter int T_RFC_PS     = 75000,
    parameter int WTR_CK       = 1,
    parameter int BURST_LEN    = 4,
    parameter int CL_HALF      = 5
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cmd_valid,
    input  logic [2:0]                   cmd_op,
    input  logic [$clog2(NUM_BANKS)-1:0] cmd_bank,
    input  logic                         cmd_ap,
    output logic                         cmd_ready,
    output logic                         cmd_illegal,
    output logic [NUM_BANKS-1:0]         bank_open,
    output logic [NUM_BANKS-1:0]         bank_overdue
);

    localparam int RCD_CK     = ns_to_ck(T_RCD_PS, TCK_PS);
    localparam int RAS_CK     = ns_to_ck(T_RAS_PS, TCK_PS);
    localparam int RAS_MAX_CK = ns_to_ck(T_RAS_MAX_PS, TCK_PS);
    localparam int RC_CK      = ns_to_ck(T_RC_PS, TCK_PS);
    localparam int RRD_CK     = ns_to_ck(T_RRD_PS, TCK_PS);
    localparam int RP_CK      = ns_to_ck(T_RP_PS, TCK_PS);
    localparam int WR_CK      = ns_to_ck(T_WR_PS, TCK_PS);
    localparam int RFC_CK     = ns_to_ck(T_RFC_PS, TCK_PS);
    localparam int BURST_CK   = BURST_LEN / 2;
    localparam int CL_CK      = (CL_HALF + 1) / 2;
    localparam int WEND_CK    = 1 + BURST_CK;
    localparam int DAL_CK     = WR_CK + RP_CK;
    localparam int R2W_CK     = CL_CK + BURST_CK;
    localparam int W2R_CK     = WEND_CK + WTR_CK;
    localparam int W2P_CK     = WEND_CK + WR_CK;
    localparam int CW = $clog2(imax(RAS_CK, RC_CK) + RP_CK + WEND_CK + DAL_CK
                               + RFC_CK + R2W_CK + 2);
    localparam int AGE_W = $clog2(RAS_MAX_CK + 1);

    op_dec_t              dec;
    logic [NUM_BANKS-1:0] bsel, pre_tgt;
    logic [NUM_BANKS-1:0] rcd_ok, pre_ok, act_ok;
    logic                 rd_ok, wr_ok, rrd_ok, rfc_ok;
    logic                 cur_open, state_bad, time_ok, issue;

    always_comb begin
        dec      = decode_op(cmd_op);
        bsel     = NUM_BANKS'(1) << cmd_bank;
        pre_tgt  = {NUM_BANKS{dec.pre}} & ({NUM_BANKS{cmd_ap}} | bsel);
        cur_open = bank_open[cmd_bank];
        state_bad = dec.bad
                  || (dec.act && cur_open)
                  || ((dec.rd || dec.wr) && !cur_open)
                  || (dec.rfsh && (|bank_open));
        time_ok = 1'b0;
        if (dec.act)  time_ok = act_ok[cmd_bank] && rrd_ok;
        if (dec.rd)   time_ok = rcd_ok[cmd_bank] && rd_ok;
        if (dec.wr)   time_ok = rcd_ok[cmd_bank] && wr_ok;
        if (dec.pre)  time_ok = &(~pre_tgt | ~bank_open | pre_ok);
        if (dec.rfsh) time_ok = &act_ok;
    end

    assign cmd_illegal = cmd_valid && state_bad;
    assign cmd_ready   = cmd_valid && !state_bad && time_ok && rfc_ok;
    assign issue       = cmd_ready;

    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
        bkg_bank #(
            .CW(CW), .AGE_W(AGE_W), .RCD_CK(RCD_CK), .RAS_CK(RAS_CK),
            .RC_CK(RC_CK), .RP_CK(RP_CK), .R2P_CK(BURST_CK), .W2P_CK(W2P_CK),
            .WEND_CK(WEND_CK), .DAL_CK(DAL_CK), .RAS_MAX_CK(RAS_MAX_CK)
        ) u_bank (
            .clk      (clk),
            .rst      (rst),
            .act_i    (issue && dec.act && bsel[k]),
            .pre_i    (issue && pre_tgt[k] && bank_open[k]),
            .rd_i     (issue && dec.rd && bsel[k]),
            .wr_i     (issue && dec.wr && bsel[k]),
            .ap_i     (cmd_ap),
            .open_o   (bank_open[k]),
            .rcd_ok_o (rcd_ok[k]),
            .pre_ok_o (pre_ok[k]),
            .act_ok_o (act_ok[k]),
            .over_o   (bank_overdue[k])
        );
    end

    bkg_bus #(
        .CW(CW), .COL_CK(BURST_CK), .R2W_CK(R2W_CK), .W2R_CK(W2R_CK),
        .RRD_CK(RRD_CK), .RFC_CK(RFC_CK)
    ) u_bus (
        .clk      (clk),
        .rst      (rst),
        .act_i    (issue && dec.act),
        .rd_i     (issue && dec.rd),
        .wr_i     (issue && dec.wr),
        .rfsh_i   (issue && dec.rfsh),
        .rd_ok_o  (rd_ok),
        .wr_ok_o  (wr_ok),
        .rrd_ok_o (rrd_ok),
        .rfc_ok_o (rfc_ok)
    );

    // R12
    ready_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(cmd_ready && (cmd_illegal || !cmd_valid)));

    // R7
    pre_all_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_ready && dec.pre && cmd_ap) |=> (bank_open == '0));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (bank_open == '0 && bank_overdue == '0));

endmodule

// File: tb/sim_ddr_bank_guard.sv
module sim_ddr_bank_guard;

    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] A = 3'd0, RD = 3'd1, WR = 3'd2, PR = 3'd3, RF = 3'd4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [1:0] cmd_bank = 2'd0;
    logic       cmd_ap = 1'b0;
    logic       cmd_ready, cmd_illegal;
    logic [3:0] bank_open, bank_overdue;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    typedef struct {
        logic       rdy;
        logic       ill;
        logic [3:0] opn;
        logic [3:0] ovr;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ddr_bank_guard #(.T_RAS_MAX_PS(300000)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_ap(cmd_ap), .cmd_ready(cmd_ready),
        .cmd_illegal(cmd_illegal), .bank_open(bank_open),
        .bank_overdue(bank_overdue)
    );

    task automatic probe(input bit v, input logic [2:0] op, input logic [1:0] b,
                         input bit ap, input bit er, input bit ei,
                         input logic [3:0] eo, input logic [3:0] ev,
                         input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        cmd_valid = v;
        cmd_op    = op;
        cmd_bank  = b;
        cmd_ap    = ap;
        e.rdy = er; e.ill = ei; e.opn = eo; e.ovr = ev; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            cmd_valid = 1'b0;
        end
    endtask

    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            compared++;
            if (cmd_ready !== e.rdy || cmd_illegal !== e.ill ||
                bank_open !== e.opn || bank_overdue !== e.ovr) begin
                mismatched++;
                $display("FAIL %s: got rdy=%0b ill=%0b open=%b over=%b, exp rdy=%0b ill=%0b open=%b over=%b",
                         e.tag, cmd_ready, cmd_illegal, bank_open, bank_overdue,
                         e.rdy, e.ill, e.opn, e.ovr);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: got hung run, exp completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        probe(0, A, 0, 0, 0, 0, 4'b0000, 4'b0000, "R1 reset state");
        // tRCD
        probe(1, A, 0, 0, 1, 0, 4'b0000, 4'b0000, "R5 act b0");
        repeat (2) probe(1, RD, 0, 0, 0, 0, 4'b0001, 4'b0000, "R2 rd before trcd");
        probe(1, RD, 0, 0, 1, 0, 4'b0001, 4'b0000, "R2 rd at trcd");
        // read to write, write to read
        repeat (4) probe(1, WR, 0, 0, 0, 0, 4'b0001, 4'b0000, "R10 wr after rd early");
        probe(1, WR, 0, 0, 1, 0, 4'b0001, 4'b0000, "R10 wr after rd");
        repeat (3) probe(1, RD, 0, 0, 0, 0, 4'b0001, 4'b0000, "R10 rd after wr early");
        probe(1, RD, 0, 0, 1, 0, 4'b0001, 4'b0000, "R10 rd after wr");
        probe(1, PR, 0, 0, 0, 0, 4'b0001, 4'b0000, "R10 pre after rd early");
        probe(1, PR, 0, 0, 1, 0, 4'b0001, 4'b0000, "R10 pre after rd");
        // tRP
        repeat (2) probe(1, A, 0, 0, 0, 0, 4'b0000, 4'b0000, "R6 act in trp");
        probe(1, A, 0, 0, 1, 0, 4'b0000, 4'b0000, "R6 act after trp");
        // tRRD, tRAS, tRC
        probe(1, A, 1, 0, 0, 0, 4'b0001, 4'b0000, "R5 act in trrd");
        probe(1, A, 1, 0, 1, 0, 4'b0001, 4'b0000, "R5 act after trrd");
        repeat (5) probe(1, PR, 1, 0, 0, 0, 4'b0011, 4'b0000, "R3 pre in tras");
        probe(1, PR, 1, 0, 1, 0, 4'b0011, 4'b0000, "R3 pre at tras");
        repeat (2) probe(1, A, 1, 0, 0, 0, 4'b0001, 4'b0000, "R5 act in trc");
        probe(1, A, 1, 0, 1, 0, 4'b0001, 4'b0000, "R5 act at trc");
        // illegal commands
        probe(1, A, 1, 0, 0, 1, 4'b0011, 4'b0000, "R12 act to open bank");
        probe(1, RD, 2, 0, 0, 1, 4'b0011, 4'b0000, "R12 rd to closed bank");
        probe(1, 3'd5, 0, 0, 0, 1, 4'b0011, 4'b0000, "R12 unused opcode");
        probe(1, RF, 0, 0, 0, 1, 4'b0011, 4'b0000, "R11 refresh with open banks");
        idle(8);
        // precharge selection
        probe(1, PR, 1, 0, 1, 0, 4'b0011, 4'b0000, "R7 single precharge");
        probe(1, PR, 3, 1, 1, 0, 4'b0001, 4'b0000, "R7 precharge all");
        // refresh
        repeat (2) probe(1, RF, 0, 0, 0, 0, 4'b0000, 4'b0000, "R11 refresh in trp");
        probe(1, RF, 0, 0, 1, 0, 4'b0000, 4'b0000, "R11 refresh");
        idle(8);
        probe(1, A, 2, 0, 0, 0, 4'b0000, 4'b0000, "R11 act in trfc");
        probe(1, A, 2, 0, 1, 0, 4'b0000, 4'b0000, "R11 act after trfc");
        // read with auto-precharge
        idle(5);
        probe(1, RD, 2, 1, 1, 0, 4'b0100, 4'b0000, "R8 rd autopre");
        probe(1, RD, 2, 0, 0, 1, 4'b0000, 4'b0000, "R8 bank closed after rd autopre");
        repeat (3) probe(1, A, 2, 0, 0, 0, 4'b0000, 4'b0000, "R8 act before autopre done");
        probe(1, A, 2, 0, 1, 0, 4'b0000, 4'b0000, "R8 act after autopre");
        // write with auto-precharge
        probe(1, A, 3, 0, 0, 0, 4'b0100, 4'b0000, "R5 act b3 in trrd");
        probe(1, A, 3, 0, 1, 0, 4'b0100, 4'b0000, "R5 act b3");
        idle(2);
        probe(1, WR, 3, 1, 1, 0, 4'b1100, 4'b0000, "R9 wr autopre");
        idle(6);
        probe(1, A, 3, 0, 0, 0, 4'b0100, 4'b0000, "R9 act in tdal");
        probe(1, A, 3, 0, 1, 0, 4'b0100, 4'b0000, "R9 act after tdal");
        idle(6);
        probe(1, PR, 0, 1, 1, 0, 4'b1100, 4'b0000, "R7 precharge all b2 b3");
        // overdue flag
        idle(2);
        probe(1, A, 0, 0, 1, 0, 4'b0000, 4'b0000, "R4 act b0");
        idle(38);
        probe(0, A, 0, 0, 0, 0, 4'b0001, 4'b0000, "R4 not yet overdue");
        probe(0, A, 0, 0, 0, 0, 4'b0001, 4'b0001, "R4 overdue");
        probe(1, PR, 0, 0, 1, 0, 4'b0001, 4'b0001, "R4 pre overdue bank");
        probe(0, A, 0, 0, 0, 0, 4'b0000, 4'b0000, "R4 overdue cleared");
        idle(2);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule